// File: doc/BRIEF.md
# Bus Transaction Capture Strobe

This block watches an asynchronous, multiplexed address/data bus whose handshake lines are all active-low. It produces a single-clock capture strobe for a trace recorder. With each strobe it presents the address and the data word of the transaction that caused it on two separate outputs. The address is taken when the bus master asserts its sync line. The data word is taken when the slave asserts its reply line. Every bus input first passes through a two-flop synchronizer on the fast system clock. After that, all decisions are made in active-high logic.

The block sorts each reply edge into one of three kinds: a write, a read, or an interrupt vector read. It also marks the transaction as DMA-like when the bus-grant acknowledge line or the refresh line is asserted. A write strobes as soon as its reply edge is seen. Reads and vector reads strobe a fixed number of clocks later, set by `DELAY_CYCLES`. Four enable inputs decide which transactions produce a strobe. A configuration input can put a read/write flag in place of address bit 15.

Top module: `cap_strobe_top`

## Requirements
- R1: Every bus input is active-low: logic 1 on a pin means deasserted. During reset, and on an idle bus with all pins high, `cap_strobe` stays 0. After reset, `cap_addr` and `cap_data` read 0.
- R2: The AD lines are latched when sync becomes asserted. With each strobe, `cap_addr` shows the address latched for that transaction.
- R3: A write is a reply edge seen while dout is asserted. It gives a one-clock `cap_strobe` that is high after the 3rd rising clock edge following the reply pin going low.
- R4: A read is a reply edge seen while din and sync are asserted and dout is not. Its strobe comes exactly `DELAY_CYCLES` clocks later than a write's would, which is after the (3+`DELAY_CYCLES`)th rising edge.
- R5: A vector read is a reply edge seen while din and iak are asserted and sync is not. It strobes with the read delay, and `cap_addr` keeps the address from the last sync assertion.
- R6: A kind strobes only when its own enable is 1 (`en_read`, `en_write`, `en_vector`). A transaction with sack or ref asserted also needs `en_dma` = 1.
- R7: `cap_data` shows the AD value sampled at the reply edge that produced the strobe.
- R8: When `rw_flag_sel` = 1, `cap_addr[15]` is 1 for a write and 0 for a read, and the other bits are unchanged. When it is 0, bit 15 is the address bit.
- R9: Each reply assertion yields at most one strobe, even if reply stays asserted for many clocks.
- R10: If sync is released before the read delay runs out, the read strobe is still issued with the data and address taken at its reply edge. A new sync assertion whose address latch lands in the strobe cycle does not change the `cap_addr` shown with that strobe.
- R11: A reply edge that is masked leaves `cap_addr` and `cap_data` as they were and gives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ad_n | input | AW | Multiplexed address/data lines, active-low |
| bus_sync_n | input | 1 | Address-valid line, active-low |
| bus_din_n | input | 1 | Data-in (read) request, active-low |
| bus_dout_n | input | 1 | Data-out (write) request, active-low |
| bus_rply_n | input | 1 | Slave reply, active-low |
| bus_iak_n | input | 1 | Interrupt acknowledge, active-low |
| bus_sack_n | input | 1 | DMA grant acknowledge, active-low |
| bus_ref_n | input | 1 | Memory refresh, active-low |
| en_read | input | 1 | Allow read strobes |
| en_write | input | 1 | Allow write strobes |
| en_vector | input | 1 | Allow vector read strobes |
| en_dma | input | 1 | Allow strobes for DMA or refresh transactions |
| rw_flag_sel | input | 1 | Put read/write flag on address bit 15 |
| cap_strobe | output | 1 | One-clock capture pulse |
| cap_addr | output | AW | Address of the strobed transaction |
| cap_data | output | AW | Data word of the strobed transaction |

## Verification
Two things can happen in the same clock: a delayed read strobe reaching the output, and the address latch of the next transaction, whose sync assertion arrives just as the delay runs out. The bench releases sync two clocks after the read reply. It then drives a new address and re-asserts sync exactly `DELAY_CYCLES` clocks after the reply pin fell, so the new latch lands in the strobe cycle. It passes only if that strobe still carries the first transaction's address and data, and the following write carries the second address.

// File: rtl/cap_strobe_pkg.sv
package cap_strobe_pkg;

  typedef enum logic [1:0] {
    XK_NONE   = 2'd0,
    XK_READ   = 2'd1,
    XK_WRITE  = 2'd2,
    XK_VECTOR = 2'd3
  } xfer_kind_t;

  // bit positions inside the synchronized control bank
  localparam int CTL_W    = 7;
  localparam int CI_SYNC  = 0;
  localparam int CI_RPLY  = 1;
  localparam int CI_DIN   = 2;
  localparam int CI_DOUT  = 3;
  localparam int CI_REF   = 4;
  localparam int CI_SACK  = 5;
  localparam int CI_IAK   = 6;

  // sort a reply edge by the handshake levels seen with it
  function automatic xfer_kind_t classify(input logic sync, input logic din,
                                          input logic dout, input logic iak);
    xfer_kind_t k;
    if (dout)                    k = XK_WRITE;
    else if (din && sync)        k = XK_READ;
    else if (din && iak && !sync) k = XK_VECTOR;
    else                         k = XK_NONE;
    return k;
  endfunction

  function automatic logic kind_allowed(input xfer_kind_t k, input logic dma_like,
                                        input logic en_rd, input logic en_wr,
                                        input logic en_vec, input logic en_dma);
    logic base;
    case (k)
      XK_READ:   base = en_rd;
      XK_WRITE:  base = en_wr;
      XK_VECTOR: base = en_vec;
      default:   base = 1'b0;
    endcase
    return base && (!dma_like || en_dma);
  endfunction

  function automatic logic kind_delayed(input xfer_kind_t k);
    return (k == XK_READ) || (k == XK_VECTOR);
  endfunction

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d_in[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/cap_qual.sv
module cap_qual
  import cap_strobe_pkg::*;
(
  input  logic rply_rise,
  input  logic sync_s,
  input  logic din_s,
  input  logic dout_s,
  input  logic iak_s,
  input  logic sack_s,
  input  logic ref_s,
  input  logic en_read,
  input  logic en_write,
  input  logic en_vector,
  input  logic en_dma,
  output logic fire_now,
  output logic arm_delay
);
  xfer_kind_t kind;
  logic       allowed;

  always_comb begin
    kind      = classify(sync_s, din_s, dout_s, iak_s);
    allowed   = rply_rise &&
                kind_allowed(kind, sack_s || ref_s, en_read, en_write, en_vector, en_dma);
    fire_now  = allowed && !kind_delayed(kind);
    arm_delay = allowed && kind_delayed(kind);
  end
endmodule

// File: rtl/cap_delay_strobe.sv
module cap_delay_strobe #(
  parameter int DELAY_CYCLES = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_now,
  input  logic arm_delay,
  output logic strobe,
  output logic pending,
  output logic expire
);
  localparam int          CW     = (DELAY_CYCLES < 2) ? 1 : $clog2(DELAY_CYCLES + 1);
  localparam logic [CW-1:0] RELOAD = CW'(DELAY_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign expire = pending && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe  <= 1'b0;
      pending <= 1'b0;
      cnt     <= '0;
    end else begin
      strobe <= fire_now || expire;
      if (arm_delay) begin
        pending <= 1'b1;
        cnt     <= RELOAD;
      end else if (expire) begin
        pending <= 1'b0;
      end else if (pending) begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/cap_strobe_top.sv
module cap_strobe_top
  import cap_strobe_pkg::*;
#(
  parameter int AW           = 18,
  parameter int DELAY_CYCLES = 25,
  parameter int FLAG_BIT     = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_ad_n,
  input  logic          bus_sync_n,
  input  logic          bus_din_n,
  input  logic          bus_dout_n,
  input  logic          bus_rply_n,
  input  logic          bus_iak_n,
  input  logic          bus_sack_n,
  input  logic          bus_ref_n,
  input  logic          en_read,
  input  logic          en_write,
  input  logic          en_vector,
  input  logic          en_dma,
  input  logic          rw_flag_sel,
  output logic          cap_strobe,
  output logic [AW-1:0] cap_addr,
  output logic [AW-1:0] cap_data
);
  // put the read/write flag in place of one address bit
  function automatic logic [AW-1:0] apply_flag(input logic [AW-1:0] a,
                                               input logic wr, input logic sel);
    logic [AW-1:0] r;
    r = a;
    if (sel) r[FLAG_BIT] = wr;
    return r;
  endfunction

  logic [CTL_W-1:0] ctl_in, ctl_s;
  logic [AW-1:0]    ad_s;

  always_comb begin
    ctl_in          = '0;
    ctl_in[CI_SYNC] = ~bus_sync_n;
    ctl_in[CI_RPLY] = ~bus_rply_n;
    ctl_in[CI_DIN]  = ~bus_din_n;
    ctl_in[CI_DOUT] = ~bus_dout_n;
    ctl_in[CI_REF]  = ~bus_ref_n;
    ctl_in[CI_SACK] = ~bus_sack_n;
    ctl_in[CI_IAK]  = ~bus_iak_n;
  end

  cap_sync #(.W(CTL_W)) u_ctl_sync (.clk(clk), .rst_n(rst_n), .d_in(ctl_in), .q(ctl_s));
  cap_sync #(.W(AW))    u_ad_sync  (.clk(clk), .rst_n(rst_n), .d_in(~bus_ad_n), .q(ad_s));

  logic sync_prev, rply_prev;
  logic sync_rise, rply_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_prev <= 1'b0;
      rply_prev <= 1'b0;
    end else begin
      sync_prev <= ctl_s[CI_SYNC];
      rply_prev <= ctl_s[CI_RPLY];
    end
  end

  assign sync_rise = ctl_s[CI_SYNC] && !sync_prev;
  assign rply_rise = ctl_s[CI_RPLY] && !rply_prev;

  logic fire_now, arm_delay, rd_pending, expire;

  cap_qual u_qual (
    .rply_rise (rply_rise),
    .sync_s    (ctl_s[CI_SYNC]),
    .din_s     (ctl_s[CI_DIN]),
    .dout_s    (ctl_s[CI_DOUT]),
    .iak_s     (ctl_s[CI_IAK]),
    .sack_s    (ctl_s[CI_SACK]),
    .ref_s     (ctl_s[CI_REF]),
    .en_read   (en_read),
    .en_write  (en_write),
    .en_vector (en_vector),
    .en_dma    (en_dma),
    .fire_now  (fire_now),
    .arm_delay (arm_delay)
  );

  cap_delay_strobe #(.DELAY_CYCLES(DELAY_CYCLES)) u_delay (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_now  (fire_now),
    .arm_delay (arm_delay),
    .strobe    (cap_strobe),
    .pending   (rd_pending),
    .expire    (expire)
  );

  logic [AW-1:0] addr_lat, cap_addr_q, cap_data_q;
  logic          cap_wr_q;
  logic          take;

  assign take = fire_now || arm_delay;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_lat   <= '0;
      cap_addr_q <= '0;
      cap_data_q <= '0;
      cap_wr_q   <= 1'b0;
    end else begin
      if (sync_rise) addr_lat <= ad_s;
      if (take) begin
        cap_addr_q <= addr_lat;
        cap_data_q <= ad_s;
        cap_wr_q   <= ctl_s[CI_DOUT];
      end
    end
  end

  assign cap_addr = apply_flag(cap_addr_q, cap_wr_q, rw_flag_sel);
  assign cap_data = cap_data_q;
endmodule

// File: rtl/cap_strobe_chk.sv
module cap_strobe_chk #(
  parameter int AW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rply_rise,
  input logic          sync_rise,
  input logic          fire_now,
  input logic          arm_delay,
  input logic          expire,
  input logic          rd_pending,
  input logic          cap_strobe,
  input logic [AW-1:0] ad_s,
  input logic [AW-1:0] addr_lat,
  input logic [AW-1:0] cap_data
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!cap_strobe);
    end
  end

  // R3
  write_strobe_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_now |=> cap_strobe);

  // R4
  read_arms_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_delay |=> rd_pending);

  // R10
  pending_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pending && !arm_delay && !expire |=> rd_pending);

  // R10
  expire_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !arm_delay |=> cap_strobe && !rd_pending);

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe && !fire_now |=> !cap_strobe);

  // R2
  addr_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rise |=> addr_lat == $past(ad_s));

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rply_rise |=> $stable(cap_data));
endmodule

bind cap_strobe_top cap_strobe_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rply_rise  (rply_rise),
  .sync_rise  (sync_rise),
  .fire_now   (fire_now),
  .arm_delay  (arm_delay),
  .expire     (expire),
  .rd_pending (rd_pending),
  .cap_strobe (cap_strobe),
  .ad_s       (ad_s),
  .addr_lat   (addr_lat),
  .cap_data   (cap_data)
);

// File: tb/cap_strobe_top_tb.sv
`timescale 1ns/1ps
module cap_strobe_top_tb;
  localparam int AW = 18;
  localparam int D  = 25;

  // kind: 0 read, 1 write, 2 vector; en = {dma, vector, write, read}
  typedef struct packed {
    logic [1:0]    kind;
    logic          sack;
    logic          rfr;
    logic [3:0]    en;
    logic          rws;
    logic [AW-1:0] addr;
    logic [AW-1:0] data;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b0, 4'hF, 1'b0, 18'h12345, 18'h0BEEF},
    '{2'd1, 1'b0, 1'b0, 4'hF, 1'b0, 18'h20010, 18'h1CAFE},
    '{2'd2, 1'b0, 1'b0, 4'hF, 1'b0, 18'h3AAAA, 18'h00104},
    '{2'd0, 1'b0, 1'b0, 4'hE, 1'b0, 18'h01111, 18'h02222},
    '{2'd1, 1'b0, 1'b0, 4'hD, 1'b0, 18'h03333, 18'h04444},
    '{2'd2, 1'b0, 1'b0, 4'hB, 1'b0, 18'h05555, 18'h06666},
    '{2'd0, 1'b1, 1'b0, 4'h7, 1'b0, 18'h07777, 18'h08888},
    '{2'd0, 1'b0, 1'b1, 4'hF, 1'b0, 18'h09999, 18'h0ABCD},
    '{2'd1, 1'b1, 1'b0, 4'hF, 1'b0, 18'h10F0F, 18'h2F0F0},
    '{2'd1, 1'b0, 1'b0, 4'hF, 1'b1, 18'h00123, 18'h15A5A},
    '{2'd0, 1'b0, 1'b0, 4'hF, 1'b1, 18'h3FFFF, 18'h0A5A5},
    '{2'd1, 1'b1, 1'b0, 4'h6, 1'b0, 18'h0C0DE, 18'h0D0D0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [AW-1:0] bus_ad_n = '1;
  logic bus_sync_n = 1'b1, bus_din_n = 1'b1, bus_dout_n = 1'b1, bus_rply_n = 1'b1;
  logic bus_iak_n = 1'b1, bus_sack_n = 1'b1, bus_ref_n = 1'b1;
  logic en_read = 1'b1, en_write = 1'b1, en_vector = 1'b1, en_dma = 1'b1;
  logic rw_flag_sel = 1'b0;
  logic cap_strobe;
  logic [AW-1:0] cap_addr, cap_data;

  cap_strobe_top #(.AW(AW), .DELAY_CYCLES(D), .FLAG_BIT(15)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_ad_n(bus_ad_n), .bus_sync_n(bus_sync_n),
    .bus_din_n(bus_din_n), .bus_dout_n(bus_dout_n), .bus_rply_n(bus_rply_n),
    .bus_iak_n(bus_iak_n), .bus_sack_n(bus_sack_n), .bus_ref_n(bus_ref_n),
    .en_read(en_read), .en_write(en_write), .en_vector(en_vector), .en_dma(en_dma),
    .rw_flag_sel(rw_flag_sel), .cap_strobe(cap_strobe), .cap_addr(cap_addr),
    .cap_data(cap_data)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cyc);
      report();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [AW-1:0] with_flag(input logic [AW-1:0] a, input bit wr,
                                              input bit sel);
    logic [AW-1:0] r;
    r = a;
    if (sel) r[15] = wr;
    return r;
  endfunction

  task automatic release_bus();
    bus_rply_n = 1'b1; bus_din_n = 1'b1; bus_dout_n = 1'b1; bus_iak_n = 1'b1;
    bus_sync_n = 1'b1; bus_sack_n = 1'b1; bus_ref_n = 1'b1;
  endtask

  logic [AW-1:0] last_addr = '0, prev_addr = '0, prev_data = '0;
  bit prev_wr = 1'b0;

  task automatic run_vec(input vec_t v);
    int nst, lat;
    bit ksel, exp_st;
    int exp_lat;
    logic [AW-1:0] sa, sd;
    nst = 0; lat = 0; sa = '0; sd = '0;
    {en_dma, en_vector, en_write, en_read} = v.en;
    rw_flag_sel = v.rws;
    bus_ad_n = ~v.addr;
    idle(2);
    if (v.kind != 2'd2) begin
      bus_sync_n = 1'b0;
      last_addr = v.addr;
    end
    idle(3);
    bus_ad_n   = ~v.data;
    bus_din_n  = (v.kind == 2'd1);
    bus_dout_n = (v.kind != 2'd1);
    bus_iak_n  = (v.kind != 2'd2);
    bus_sack_n = ~v.sack;
    bus_ref_n  = ~v.rfr;
    idle(3);
    bus_rply_n = 1'b0;
    for (int i = 1; i <= D + 10; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (cap_strobe) begin
        nst++;
        if (nst == 1) begin
          lat = i; sa = cap_addr; sd = cap_data;
        end
      end
    end
    ksel    = (v.kind == 2'd0) ? v.en[0] : (v.kind == 2'd1) ? v.en[1] : v.en[2];
    exp_st  = ksel && (!(v.sack || v.rfr) || v.en[3]);
    exp_lat = (v.kind == 2'd1) ? 3 : 3 + D;
    if (exp_st) begin
      check(nst == 1, (v.sack || v.rfr) ? "R6/R9 enabled DMA-like gives one strobe"
                                        : "R9 one strobe per reply", nst, 1);
      check(lat == exp_lat, (v.kind == 2'd1) ? "R3 write strobe timing" :
            (v.kind == 2'd0) ? "R4 read strobe timing" : "R5 vector strobe timing",
            lat, exp_lat);
      check(sa == with_flag(last_addr, v.kind == 2'd1, v.rws),
            v.rws ? "R8 flag on bit 15" : (v.kind == 2'd2) ? "R5 vector keeps address"
                                                          : "R2 address with strobe",
            sa, with_flag(last_addr, v.kind == 2'd1, v.rws));
      check(sd == v.data, "R7 data at reply edge", sd, v.data);
      prev_addr = last_addr; prev_data = v.data; prev_wr = (v.kind == 2'd1);
    end else begin
      check(nst == 0, "R6 masked kind gives no strobe", nst, 0);
      check(cap_addr == with_flag(prev_addr, prev_wr, v.rws),
            "R11 masked edge leaves address", cap_addr, with_flag(prev_addr, prev_wr, v.rws));
      check(cap_data == prev_data, "R11 masked edge leaves data", cap_data, prev_data);
    end
    release_bus();
    idle(6);
  endtask

  initial begin
    int nst;
    logic [AW-1:0] a1, x1, a2, x2;
    idle(3);
    check(cap_strobe == 1'b0, "R1 no strobe in reset", cap_strobe, 0);
    @(negedge clk) rst_n = 1'b1;
    idle(20);
    check(cap_strobe == 1'b0, "R1 idle bus no strobe", cap_strobe, 0);
    check(cap_addr == '0, "R1 address after reset", cap_addr, 0);
    check(cap_data == '0, "R1 data after reset", cap_data, 0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R10: sync released early; next sync latches in the strobe cycle
    a1 = 18'h2468A; x1 = 18'h13579; a2 = 18'h0FACE; x2 = 18'h3D00D;
    {en_dma, en_vector, en_write, en_read} = 4'hF;
    rw_flag_sel = 1'b0;
    bus_ad_n = ~a1; idle(2);
    bus_sync_n = 1'b0; idle(3);
    bus_ad_n = ~x1; bus_din_n = 1'b0; idle(3);
    bus_rply_n = 1'b0;
    nst = 0;
    for (int i = 1; i <= D + 8; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (cap_strobe) begin
        nst++;
        check(i == D + 3, "R10 read strobe after early sync release", i, D + 3);
        check(cap_addr == a1, "R10 address unchanged by same-cycle latch", cap_addr, a1);
        check(cap_data == x1, "R10 data from reply edge", cap_data, x1);
      end
      if (i == 2) begin
        bus_sync_n = 1'b1; bus_din_n = 1'b1; bus_ad_n = ~a2;
      end
      if (i == D) bus_sync_n = 1'b0;
    end
    check(nst == 1, "R10 exactly one delayed strobe", nst, 1);
    bus_rply_n = 1'b1; idle(4);
    bus_ad_n = ~x2; bus_dout_n = 1'b0; idle(3);
    bus_rply_n = 1'b0;
    idle(3);
    check(cap_strobe == 1'b1, "R3 write strobe after overlap", cap_strobe, 1);
    check(cap_addr == a2, "R2 second address latched", cap_addr, a2);
    check(cap_data == x2, "R7 second data", cap_data, x2);
    idle(1);
    check(cap_strobe == 1'b0, "R9 strobe lasts one clock", cap_strobe, 0);
    release_bus();
    idle(5);

    report();
    $finish;
  end
endmodule